// File: doc/BRIEF.md
# Per-Class Buffer Pause and Full Threshold Generator

This block watches the number of free blocks left in a shared receive buffer. From that count it produces two flags for each of two traffic classes: a pause request, which asks the link partner to stop sending, and a near-full flag, which reports that the buffer is close to running out. It also produces one near-full flag for the loopback path. Each flag has an assert threshold and a separate release threshold, so it switches with hysteresis. The count must fall strictly below the assert threshold to raise the flag. It must rise strictly above the release threshold to drop it. Between the two thresholds the flag keeps its value.

Two built-in threshold sets exist. The pauseable set raises pause early. In the non-pauseable set pause can never be raised, and only the near-full flag reacts. When priority flow control mode is on, each class takes its set from its own pauseable bit. When the mode is off, class 0 always uses the pauseable set and class 1 uses four thresholds supplied on input pins. All flags are registered. A new count, threshold, mode or flag value takes effect at the next rising clock edge. All pins are plain level signals with no handshake.

Top module: `buf_thresh_gen`

## Requirements
- R1: While reset is active, every output (pause_req, near_full, lb_full) is 0.
- R2: A pause_req bit becomes 1 at the clock edge after free_blocks is strictly below that class's pause-assert threshold.
- R3: A pause_req bit becomes 0 at the edge after free_blocks is strictly above its pause-release threshold and not below its assert threshold. Otherwise the bit keeps its value.
- R4: A near_full bit follows the same hysteresis rule, using its own full-assert and full-release thresholds.
- R5: The pauseable set is: pause-assert 170, pause-release 250, full-assert 10, full-release 50.
- R6: The non-pauseable set is: pause-assert 0, pause-release 0, full-assert 90, full-release 250. A class using it never raises pause_req, even at a count of 0.
- R7: With pfc_mode=0, class 0 (bit 0) uses the pauseable set whatever pauseable[0] is. Class 1 (bit 1) uses c1_pause_on, c1_pause_off, c1_full_on and c1_full_off.
- R8: With pfc_mode=1, class n uses the pauseable set when pauseable[n]=1 and the non-pauseable set when pauseable[n]=0. The c1_* pins are ignored.
- R9: lb_full asserts when free_blocks is below 170 and releases when it is above 250. It holds its value in between.
- R10: The comparisons are strict. A count equal to an assert threshold does not raise a flag, and a count equal to a release threshold does not drop it.
- R11: A change of pfc_mode, pauseable or a threshold input is reflected in the outputs at the next clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| free_blocks | input | 10 | Current free-block count of the receive buffer |
| pfc_mode | input | 1 | 1 = priority flow control mode, each class picks its set from its own flag |
| pauseable | input | 2 | Per-class pauseable flag, bit n for class n |
| c1_pause_on | input | 10 | Class 1 pause-assert threshold, used when pfc_mode=0 |
| c1_pause_off | input | 10 | Class 1 pause-release threshold, used when pfc_mode=0 |
| c1_full_on | input | 10 | Class 1 full-assert threshold, used when pfc_mode=0 |
| c1_full_off | input | 10 | Class 1 full-release threshold, used when pfc_mode=0 |
| pause_req | output | 2 | Per-class pause request, bit n for class n |
| near_full | output | 2 | Per-class near-full flag, bit n for class n |
| lb_full | output | 1 | Loopback near-full flag |

## Verification
On every cycle, the assertions check each hysteresis flag against the count and the thresholds it actually received. A flag must set below its assert threshold, clear above its release threshold, and hold in between. The assertions also check that a class in non-pauseable mode never raises pause, and that class 0 follows the pauseable set when the mode is off. Whether the right threshold set reaches each class can only be shown by the bench scenarios. These cover the fixed values of both sets, the use of the class 1 pins outside the mode, the exact boundaries where the comparisons are strict, and a flag change while the count is steady.

// File: rtl/buf_thresh_pkg.sv
package buf_thresh_pkg;
  parameter int CNT_W   = 10;
  parameter int NUM_CLS = 2;

  typedef struct packed {
    logic [CNT_W-1:0] pause_on;
    logic [CNT_W-1:0] pause_off;
    logic [CNT_W-1:0] full_on;
    logic [CNT_W-1:0] full_off;
  } thr_set_t;

  // threshold set for a class that may be paused
  localparam thr_set_t PSET = '{
    pause_on:  CNT_W'(170),
    pause_off: CNT_W'(250),
    full_on:   CNT_W'(10),
    full_off:  CNT_W'(50)
  };

  // threshold set for a class that must not be paused
  localparam thr_set_t NSET = '{
    pause_on:  CNT_W'(0),
    pause_off: CNT_W'(0),
    full_on:   CNT_W'(90),
    full_off:  CNT_W'(250)
  };

  localparam logic [CNT_W-1:0] LB_ON  = CNT_W'(170);
  localparam logic [CNT_W-1:0] LB_OFF = CNT_W'(250);
endpackage

// File: rtl/thr_select.sv
module thr_select
  import buf_thresh_pkg::*;
(
  input  logic     pfc_mode,
  input  logic     pauseable,
  input  logic     prog_valid,
  input  thr_set_t prog,
  output thr_set_t sel
);
  always_comb begin
    if (pfc_mode)
      sel = pauseable ? PSET : NSET;
    else if (prog_valid)
      sel = prog;
    else
      sel = PSET;
  end
endmodule

// File: rtl/hyst_flag.sv
module hyst_flag #(
  parameter int W = 10
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] level,
  input  logic [W-1:0] on_th,
  input  logic [W-1:0] off_th,
  output logic         flag
);
  logic below_on;
  logic above_off;

  assign below_on  = level < on_th;
  assign above_off = level > off_th;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)
      flag <= 1'b0;
    else if (below_on)
      flag <= 1'b1;
    else if (above_off)
      flag <= 1'b0;
  end

  // R2 R4
  set_below_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (level < on_th) |=> flag);

  // R3 R4
  clear_above_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ((level > off_th) && !(level < on_th)) |=> !flag);

  // R10
  hold_between_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!(level < on_th) && !(level > off_th)) |=> $stable(flag));
endmodule

// File: rtl/buf_thresh_gen.sv
module buf_thresh_gen
  import buf_thresh_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  logic [CNT_W-1:0]   free_blocks,
  input  logic               pfc_mode,
  input  logic [NUM_CLS-1:0] pauseable,
  input  logic [CNT_W-1:0]   c1_pause_on,
  input  logic [CNT_W-1:0]   c1_pause_off,
  input  logic [CNT_W-1:0]   c1_full_on,
  input  logic [CNT_W-1:0]   c1_full_off,
  output logic [NUM_CLS-1:0] pause_req,
  output logic [NUM_CLS-1:0] near_full,
  output logic               lb_full
);
  thr_set_t prog_arr [NUM_CLS];
  thr_set_t sel_arr  [NUM_CLS];

  always_comb begin
    prog_arr[0] = PSET;
    prog_arr[1] = '{pause_on: c1_pause_on, pause_off: c1_pause_off,
                    full_on: c1_full_on, full_off: c1_full_off};
  end

  for (genvar c = 0; c < NUM_CLS; c++) begin : g_cls
    thr_select u_sel (
      .pfc_mode  (pfc_mode),
      .pauseable (pauseable[c]),
      .prog_valid(c != 0),
      .prog      (prog_arr[c]),
      .sel       (sel_arr[c])
    );

    hyst_flag #(.W(CNT_W)) u_pause (
      .clk   (clk),
      .rst_n (rst_n),
      .level (free_blocks),
      .on_th (sel_arr[c].pause_on),
      .off_th(sel_arr[c].pause_off),
      .flag  (pause_req[c])
    );

    hyst_flag #(.W(CNT_W)) u_full (
      .clk   (clk),
      .rst_n (rst_n),
      .level (free_blocks),
      .on_th (sel_arr[c].full_on),
      .off_th(sel_arr[c].full_off),
      .flag  (near_full[c])
    );

    // R6
    nonpause_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pfc_mode && !pauseable[c] && !pause_req[c]) |=> !pause_req[c]);
  end

  hyst_flag #(.W(CNT_W)) u_lb (
    .clk   (clk),
    .rst_n (rst_n),
    .level (free_blocks),
    .on_th (LB_ON),
    .off_th(LB_OFF),
    .flag  (lb_full)
  );

  // R7
  cls0_default_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!pfc_mode && (free_blocks < PSET.pause_on)) |=> pause_req[0]);

  // R9
  lb_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (free_blocks < LB_ON) |=> lb_full);
endmodule

// File: tb/buf_thresh_gen_test.sv
module buf_thresh_gen_test;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic [9:0] free_blocks = 10'd512;
  logic       pfc_mode = 1'b0;
  logic [1:0] pauseable = 2'b00;
  logic [9:0] c1_pause_on = 10'd100;
  logic [9:0] c1_pause_off = 10'd200;
  logic [9:0] c1_full_on = 10'd20;
  logic [9:0] c1_full_off = 10'd40;
  logic [1:0] pause_req;
  logic [1:0] near_full;
  logic       lb_full;
  int total = 0;
  int bad = 0;

  always #10 clk = ~clk;

  buf_thresh_gen uut (
    .clk(clk), .rst_n(rst_n), .free_blocks(free_blocks),
    .pfc_mode(pfc_mode), .pauseable(pauseable),
    .c1_pause_on(c1_pause_on), .c1_pause_off(c1_pause_off),
    .c1_full_on(c1_full_on), .c1_full_off(c1_full_off),
    .pause_req(pause_req), .near_full(near_full), .lb_full(lb_full)
  );

  task automatic chk(string req, logic act, logic exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s: actual=%0b expected=%0b (count=%0d)", req, act, exp, free_blocks);
    end
  endtask

  // drive a count at a falling edge, let one rising edge pass, sample at the next falling edge
  task automatic step(logic [9:0] cnt);
    free_blocks = cnt;
    @(negedge clk);
  endtask

  task automatic t_reset();
    @(negedge clk);
    chk("R1 pause_req[0]", pause_req[0], 1'b0);
    chk("R1 pause_req[1]", pause_req[1], 1'b0);
    chk("R1 near_full[0]", near_full[0], 1'b0);
    chk("R1 near_full[1]", near_full[1], 1'b0);
    chk("R1 lb_full", lb_full, 1'b0);
    rst_n = 1'b1;
    @(negedge clk);
  endtask

  task automatic t_cls0_pause();
    step(10'd512);
    step(10'd171); chk("R2 above assert", pause_req[0], 1'b0);
    step(10'd170); chk("R10 equal assert", pause_req[0], 1'b0);
    step(10'd169); chk("R2 R5 below assert", pause_req[0], 1'b1);
    step(10'd250); chk("R10 equal release", pause_req[0], 1'b1);
    step(10'd251); chk("R3 above release", pause_req[0], 1'b0);
  endtask

  task automatic t_cls0_full();
    step(10'd512);
    step(10'd11); chk("R4 above full assert", near_full[0], 1'b0);
    step(10'd10); chk("R10 equal full assert", near_full[0], 1'b0);
    step(10'd9);  chk("R4 R5 full set", near_full[0], 1'b1);
    chk("R5 pause during full", pause_req[0], 1'b1);
    step(10'd50); chk("R10 full hold", near_full[0], 1'b1);
    step(10'd51); chk("R4 R5 full release", near_full[0], 1'b0);
    chk("R3 pause holds", pause_req[0], 1'b1);
    step(10'd300); chk("R3 pause release", pause_req[0], 1'b0);
  endtask

  task automatic t_cls1_prog();
    pfc_mode = 1'b0;
    pauseable = 2'b10;
    step(10'd512);
    step(10'd150);
    chk("R7 cls1 uses pins", pause_req[1], 1'b0);
    chk("R7 cls0 pauseable set", pause_req[0], 1'b1);
    step(10'd99); chk("R7 cls1 pin assert", pause_req[1], 1'b1);
    step(10'd15);
    chk("R7 cls1 pin full", near_full[1], 1'b1);
    chk("R7 cls0 full", near_full[0], 1'b0);
    step(10'd300);
    chk("R7 cls1 release", pause_req[1], 1'b0);
    chk("R7 cls1 full release", near_full[1], 1'b0);
  endtask

  task automatic t_pfc_mixed();
    pfc_mode = 1'b1;
    pauseable = 2'b01;
    step(10'd512);
    step(10'd95);
    chk("R8 pins ignored", pause_req[1], 1'b0);
    chk("R6 full not yet", near_full[1], 1'b0);
    chk("R8 cls0 pause", pause_req[0], 1'b1);
    step(10'd89);
    chk("R6 nonpause full set", near_full[1], 1'b1);
    chk("R5 cls0 full clear", near_full[0], 1'b0);
    step(10'd0);
    chk("R6 no pause at zero", pause_req[1], 1'b0);
    chk("R4 cls0 full", near_full[0], 1'b1);
    step(10'd250);
    chk("R6 full holds at 250", near_full[1], 1'b1);
    chk("R4 cls0 full release", near_full[0], 1'b0);
    chk("R10 cls0 pause holds", pause_req[0], 1'b1);
    step(10'd251);
    chk("R6 full release", near_full[1], 1'b0);
    chk("R3 cls0 pause release", pause_req[0], 1'b0);
  endtask

  task automatic t_pfc_swap();
    pfc_mode = 1'b1;
    pauseable = 2'b10;
    step(10'd300);
    step(10'd150);
    chk("R8 cls0 nonpause", pause_req[0], 1'b0);
    chk("R8 cls1 pauseable", pause_req[1], 1'b1);
    chk("R6 cls0 full", near_full[0], 1'b0);
    pauseable = 2'b11;
    @(negedge clk);
    chk("R11 flag change next edge", pause_req[0], 1'b1);
    pfc_mode = 1'b0;
    @(negedge clk);
    chk("R11 mode change keeps cls1 via pins hold", pause_req[1], 1'b1);
    c1_pause_off = 10'd140;
    @(negedge clk);
    chk("R11 threshold change next edge", pause_req[1], 1'b0);
    c1_pause_off = 10'd200;
    step(10'd512);
  endtask

  task automatic t_loopback();
    pfc_mode = 1'b0;
    step(10'd300); chk("R9 idle", lb_full, 1'b0);
    step(10'd170); chk("R9 R10 equal", lb_full, 1'b0);
    step(10'd169); chk("R9 set", lb_full, 1'b1);
    step(10'd250); chk("R9 hold", lb_full, 1'b1);
    step(10'd251); chk("R9 release", lb_full, 1'b0);
  endtask

  initial begin
    #(200000 * 20);
    total++;
    bad++;
    $display("FAIL watchdog: actual=timeout expected=completion");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (3) @(posedge clk);
    t_reset();
    t_cls0_pause();
    t_cls0_full();
    t_cls1_prog();
    t_pfc_mixed();
    t_pfc_swap();
    t_loopback();
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule